// File: doc/BRIEF.md
# Associative TLB lookup unit

This block is a fully associative translation buffer for a 32-bit virtual address space. Software loads entries through a write port that takes an entry index and all entry fields in one cycle. Each entry describes a pair of adjacent pages, one even and one odd. It holds a virtual page-pair number, a page-size mask, an 8-bit address-space tag, a global flag, and two physical frame numbers. Each frame number has its own valid and dirty flag.

A lookup presents a virtual address, the current address-space tag and a read/write flag. Every entry is compared in parallel. The lowest-indexed hit wins. The selected half is then checked for validity and, on writes, for the dirty flag. One cycle later the unit returns a result code, a physical address and a write-permission flag, together with a response strobe. The minimum page is 4 KB, so the smallest pair covers 8 KB.

Top module: `tlb_lookup_unit`

## Requirements
- R1: After reset the response strobe is low and no entry is loaded, so any lookup returns NOMATCH until entries are written.
- R2: An entry hits when it is loaded, when its global flag is set or its stored tag equals the lookup tag, and when the address bits above the effective mask equal the stored page-pair number.
- R3: The page-size mask field has bit k standing for address bit 13+k and must hold contiguous low ones. The effective mask is that field with address bits 12..0 forced to one: a mask of 0 gives 4 KB pages and a mask of 3 gives 16 KB pages.
- R4: The half is selected by the highest bit of the effective mask, which is bit 12 for 4 KB pages and bit 14 for 16 KB pages. When that bit is 1 the odd frame is used, and when it is 0 the even frame is used.
- R5: If the selected half is not valid, the result code is 2 (INVALID).
- R6: A write lookup that reaches a valid half with a clear dirty flag gives code 3 (DIRTY). A read lookup never gives code 3.
- R7: On success the code is 0 (MATCH). The physical address is the frame number shifted left by 12, ORed with the address bits below the selected half-page boundary. The write-permission output equals the half's dirty flag.
- R8: If no entry hits, the code is 1 (NOMATCH). For every code other than 0, the physical address is 0 and write permission is low.
- R9: When several entries hit, the lowest index decides the result.
- R10: A lookup request gives a response strobe exactly one cycle later. In a cycle with no request the strobe is low and the response fields hold their values.
- R11: A write replaces the whole entry at its index. Lookups issued from the next cycle on see the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Entry write strobe |
| wr_idx_i | input | 4 | Entry index to write |
| wr_vpn_i | input | 19 | Page-pair number, address bits 31..13 |
| wr_pmask_i | input | 19 | Page-size mask, bit k for address bit 13+k |
| wr_asid_i | input | 8 | Address-space tag of the entry |
| wr_global_i | input | 1 | Entry matches any tag |
| wr_pfn0_i | input | 20 | Even-page frame number |
| wr_v0_i | input | 1 | Even-page valid |
| wr_d0_i | input | 1 | Even-page dirty (writable) |
| wr_pfn1_i | input | 20 | Odd-page frame number |
| wr_v1_i | input | 1 | Odd-page valid |
| wr_d1_i | input | 1 | Odd-page dirty (writable) |
| lk_req_i | input | 1 | Lookup request |
| lk_vaddr_i | input | 32 | Virtual address to translate |
| lk_asid_i | input | 8 | Current address-space tag |
| lk_write_i | input | 1 | 1 for a store access, 0 for a load |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_code_o | output | 2 | 0 MATCH, 1 NOMATCH, 2 INVALID, 3 DIRTY |
| rsp_paddr_o | output | 32 | Physical address, 0 unless MATCH |
| rsp_writable_o | output | 1 | Page may be written |

## Verification
The hardest case to reach is the one where several entries hit at once, because software would normally avoid it. The bench loads two entries at indices 1 and 12 with the same page-pair number and tag, then checks that index 1 decides the result. It then rewrites index 1 with a different page and checks that index 12 now takes over. Half selection for large pages is also hard to reach. The bench covers it with a 16 KB entry, probing addresses on both sides of bit 14 and one address just past the pair.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W     = 32;
  localparam int MIN_PG   = 12;
  localparam int ASID_W   = 8;
  localparam int PAIR_LSB = MIN_PG + 1;
  localparam int VPN_W    = VA_W - PAIR_LSB;
  localparam int PFN_W    = VA_W - MIN_PG;

  typedef enum logic [1:0] {
    RES_MATCH   = 2'd0,
    RES_NOMATCH = 2'd1,
    RES_INVALID = 2'd2,
    RES_DIRTY   = 2'd3
  } tlb_res_e;

  typedef struct packed {
    logic              present;
    logic [VPN_W-1:0]  vpn;
    logic [VPN_W-1:0]  pmask;
    logic [ASID_W-1:0] asid;
    logic              global_b;
    logic [PFN_W-1:0]  pfn0;
    logic              v0;
    logic              d0;
    logic [PFN_W-1:0]  pfn1;
    logic              v1;
    logic              d1;
  } tlb_entry_t;
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_pkg::*;
#(
  parameter  int NUM_ENTRIES = 16,
  localparam int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  tlb_entry_t       wr_entry_i,
  output tlb_entry_t       entries_o [NUM_ENTRIES]
);
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   entries_o[g] <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))     entries_o[g] <= wr_entry_i;
    end
  end
endmodule

// File: rtl/tlb_match_lane.sv
module tlb_match_lane
  import tlb_pkg::*;
(
  input  logic              present_i,
  input  logic [VPN_W-1:0]  vpn_i,
  input  logic [VPN_W-1:0]  pmask_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic              global_i,
  input  logic [VA_W-1:0]   vaddr_i,
  input  logic [ASID_W-1:0] cur_asid_i,
  output logic              hit_o,
  output logic              odd_o
);
  logic [VA_W-1:0] emask;
  logic            tag_eq;

  always_comb begin
    emask  = {pmask_i, {PAIR_LSB{1'b1}}};
    tag_eq = ((vaddr_i ^ {vpn_i, {PAIR_LSB{1'b0}}}) & ~emask) == '0;
    hit_o  = present_i && (global_i || asid_i == cur_asid_i) && tag_eq;
    // top bit of the effective mask picks the half
    odd_o  = |(vaddr_i & emask & ~(emask >> 1));
  end
endmodule

// File: rtl/tlb_resolve.sv
module tlb_resolve
  import tlb_pkg::*;
#(
  parameter  int NUM_ENTRIES = 16,
  localparam int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic [NUM_ENTRIES-1:0] hit_i,
  input  logic [NUM_ENTRIES-1:0] odd_i,
  input  logic [VPN_W-1:0]       pmask_i [NUM_ENTRIES],
  input  logic [PFN_W-1:0]       pfn0_i  [NUM_ENTRIES],
  input  logic [PFN_W-1:0]       pfn1_i  [NUM_ENTRIES],
  input  logic [NUM_ENTRIES-1:0] v0_i,
  input  logic [NUM_ENTRIES-1:0] d0_i,
  input  logic [NUM_ENTRIES-1:0] v1_i,
  input  logic [NUM_ENTRIES-1:0] d1_i,
  input  logic [VA_W-1:0]        vaddr_i,
  input  logic                   write_i,
  output tlb_res_e               code_o,
  output logic [VA_W-1:0]        paddr_o,
  output logic                   writable_o
);
  logic [IDX_W-1:0] sel;
  logic             any;
  logic [VA_W-1:0]  half_mask;
  logic             odd, v, d;
  logic [PFN_W-1:0] pfn;

  always_comb begin
    sel = '0;
    any = 1'b0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        sel = IDX_W'(i);
        any = 1'b1;
      end
    end
    half_mask = {pmask_i[sel], {PAIR_LSB{1'b1}}} >> 1;
    odd       = odd_i[sel];
    v         = odd ? v1_i[sel]   : v0_i[sel];
    d         = odd ? d1_i[sel]   : d0_i[sel];
    pfn       = odd ? pfn1_i[sel] : pfn0_i[sel];

    code_o     = RES_NOMATCH;
    paddr_o    = '0;
    writable_o = 1'b0;
    if (any) begin
      if (!v)                 code_o = RES_INVALID;
      else if (write_i && !d) code_o = RES_DIRTY;
      else begin
        code_o     = RES_MATCH;
        paddr_o    = {pfn, {MIN_PG{1'b0}}} | (vaddr_i & half_mask);
        writable_o = d;
      end
    end
  end
endmodule

// File: rtl/tlb_lookup_unit.sv
module tlb_lookup_unit
  import tlb_pkg::*;
#(
  parameter  int NUM_ENTRIES = 16,
  localparam int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [VPN_W-1:0]  wr_vpn_i,
  input  logic [VPN_W-1:0]  wr_pmask_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic              wr_global_i,
  input  logic [PFN_W-1:0]  wr_pfn0_i,
  input  logic              wr_v0_i,
  input  logic              wr_d0_i,
  input  logic [PFN_W-1:0]  wr_pfn1_i,
  input  logic              wr_v1_i,
  input  logic              wr_d1_i,
  input  logic              lk_req_i,
  input  logic [VA_W-1:0]   lk_vaddr_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic              lk_write_i,
  output logic              rsp_valid_o,
  output logic [1:0]        rsp_code_o,
  output logic [VA_W-1:0]   rsp_paddr_o,
  output logic              rsp_writable_o
);
  tlb_entry_t             wr_entry;
  tlb_entry_t             entries [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] hit, odd, v0, d0, v1, d1;
  logic [VPN_W-1:0]       pmask_a [NUM_ENTRIES];
  logic [PFN_W-1:0]       pfn0_a  [NUM_ENTRIES];
  logic [PFN_W-1:0]       pfn1_a  [NUM_ENTRIES];
  tlb_res_e               code_c;
  logic [VA_W-1:0]        paddr_c;
  logic                   wr_ok_c;

  always_comb begin
    wr_entry          = '0;
    wr_entry.present  = 1'b1;
    wr_entry.vpn      = wr_vpn_i;
    wr_entry.pmask    = wr_pmask_i;
    wr_entry.asid     = wr_asid_i;
    wr_entry.global_b = wr_global_i;
    wr_entry.pfn0     = wr_pfn0_i;
    wr_entry.v0       = wr_v0_i;
    wr_entry.d0       = wr_d0_i;
    wr_entry.pfn1     = wr_pfn1_i;
    wr_entry.v1       = wr_v1_i;
    wr_entry.d1       = wr_d1_i;
  end

  tlb_entry_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_idx_i   (wr_idx_i),
    .wr_entry_i (wr_entry),
    .entries_o  (entries)
  );

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_lane
    assign pmask_a[g] = entries[g].pmask;
    assign pfn0_a[g]  = entries[g].pfn0;
    assign pfn1_a[g]  = entries[g].pfn1;
    assign v0[g]      = entries[g].v0;
    assign d0[g]      = entries[g].d0;
    assign v1[g]      = entries[g].v1;
    assign d1[g]      = entries[g].d1;

    tlb_match_lane u_lane (
      .present_i  (entries[g].present),
      .vpn_i      (entries[g].vpn),
      .pmask_i    (entries[g].pmask),
      .asid_i     (entries[g].asid),
      .global_i   (entries[g].global_b),
      .vaddr_i    (lk_vaddr_i),
      .cur_asid_i (lk_asid_i),
      .hit_o      (hit[g]),
      .odd_o      (odd[g])
    );
  end

  tlb_resolve #(.NUM_ENTRIES(NUM_ENTRIES)) u_resolve (
    .hit_i      (hit),
    .odd_i      (odd),
    .pmask_i    (pmask_a),
    .pfn0_i     (pfn0_a),
    .pfn1_i     (pfn1_a),
    .v0_i       (v0),
    .d0_i       (d0),
    .v1_i       (v1),
    .d1_i       (d1),
    .vaddr_i    (lk_vaddr_i),
    .write_i    (lk_write_i),
    .code_o     (code_c),
    .paddr_o    (paddr_c),
    .writable_o (wr_ok_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o    <= 1'b0;
      rsp_code_o     <= RES_NOMATCH;
      rsp_paddr_o    <= '0;
      rsp_writable_o <= 1'b0;
    end else begin
      rsp_valid_o <= lk_req_i;
      if (lk_req_i) begin
        rsp_code_o     <= code_c;
        rsp_paddr_o    <= paddr_c;
        rsp_writable_o <= wr_ok_c;
      end
    end
  end
endmodule

// File: rtl/tlb_lookup_unit_chk.sv
module tlb_lookup_unit_chk
  import tlb_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            lk_req_i,
  input logic            lk_write_i,
  input logic [VA_W-1:0] lk_vaddr_i,
  input logic            rsp_valid_o,
  input logic [1:0]      rsp_code_o,
  input logic [VA_W-1:0] rsp_paddr_o,
  input logic            rsp_writable_o
);
  localparam logic [VA_W-1:0] OFF_MASK = VA_W'((64'd1 << MIN_PG) - 1);

  AST_RSP_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_req_i |=> rsp_valid_o); // R10
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_req_i |=> !rsp_valid_o); // R10
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_req_i |=> $stable(rsp_code_o) && $stable(rsp_paddr_o) && $stable(rsp_writable_o)); // R10
  AST_READ_NEVER_DIRTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_req_i && !lk_write_i |=> rsp_code_o != 2'd3); // R6
  AST_WRITABLE_ON_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_writable_o |-> rsp_code_o == 2'd0); // R7
  AST_OFFSET_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_req_i |=> rsp_code_o != 2'd0 || ((rsp_paddr_o ^ $past(lk_vaddr_i)) & OFF_MASK) == '0); // R7
  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_code_o != 2'd0 |-> rsp_paddr_o == '0 && !rsp_writable_o); // R8
endmodule

bind tlb_lookup_unit tlb_lookup_unit_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .lk_req_i       (lk_req_i),
  .lk_write_i     (lk_write_i),
  .lk_vaddr_i     (lk_vaddr_i),
  .rsp_valid_o    (rsp_valid_o),
  .rsp_code_o     (rsp_code_o),
  .rsp_paddr_o    (rsp_paddr_o),
  .rsp_writable_o (rsp_writable_o)
);

// File: tb/tb_tlb_lookup_unit.sv
`timescale 1ns/1ps
module tb_tlb_lookup_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [18:0] wr_vpn = '0, wr_pmask = '0;
  logic [7:0]  wr_asid = '0;
  logic        wr_global = 1'b0;
  logic [19:0] wr_pfn0 = '0, wr_pfn1 = '0;
  logic        wr_v0 = 1'b0, wr_d0 = 1'b0, wr_v1 = 1'b0, wr_d1 = 1'b0;
  logic        lk_req = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_asid = '0;
  logic        lk_write = 1'b0;
  logic        rsp_valid;
  logic [1:0]  rsp_code;
  logic [31:0] rsp_paddr;
  logic        rsp_writable;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tlb_lookup_unit dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_vpn_i(wr_vpn), .wr_pmask_i(wr_pmask),
    .wr_asid_i(wr_asid), .wr_global_i(wr_global),
    .wr_pfn0_i(wr_pfn0), .wr_v0_i(wr_v0), .wr_d0_i(wr_d0),
    .wr_pfn1_i(wr_pfn1), .wr_v1_i(wr_v1), .wr_d1_i(wr_d1),
    .lk_req_i(lk_req), .lk_vaddr_i(lk_vaddr), .lk_asid_i(lk_asid), .lk_write_i(lk_write),
    .rsp_valid_o(rsp_valid), .rsp_code_o(rsp_code), .rsp_paddr_o(rsp_paddr),
    .rsp_writable_o(rsp_writable)
  );

  task automatic write_entry(input logic [3:0] idx, input logic [18:0] vpn, input logic [18:0] pm,
                             input logic [7:0] asid, input logic g,
                             input logic [19:0] p0, input logic v0, input logic d0,
                             input logic [19:0] p1, input logic v1, input logic d1);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_vpn = vpn; wr_pmask = pm; wr_asid = asid; wr_global = g;
    wr_pfn0 = p0; wr_v0 = v0; wr_d0 = d0; wr_pfn1 = p1; wr_v1 = v1; wr_d1 = d1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] va, input logic [7:0] asid, input logic wr,
                        input logic [1:0] e_code, input logic [31:0] e_pa, input logic e_w,
                        input string req);
    @(negedge clk);
    lk_req = 1'b1; lk_vaddr = va; lk_asid = asid; lk_write = wr;
    @(negedge clk);
    lk_req = 1'b0;
    checks++;
    if (!(rsp_valid && rsp_code == e_code && rsp_paddr == e_pa && rsp_writable == e_w)) begin
      errors++;
      $display("FAIL %s va=%h: got v=%0b code=%0d pa=%h w=%0b, expected v=1 code=%0d pa=%h w=%0b",
               req, va, rsp_valid, rsp_code, rsp_paddr, rsp_writable, e_code, e_pa, e_w);
    end
  endtask

  task automatic t_reset;
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset strobe: got %0b expected 0", rsp_valid);
    end
    lookup(32'h0000_0000, 8'h00, 1'b0, 2'd1, 32'h0, 1'b0, "R1 empty buffer");
    lookup(32'h8000_0000, 8'h00, 1'b1, 2'd1, 32'h0, 1'b0, "R1 empty buffer store");
  endtask

  task automatic t_small_page;
    write_entry(4'd3, 19'h00200, 19'h0, 8'h05, 1'b0, 20'h12345, 1'b1, 1'b1, 20'h0ABCD, 1'b1, 1'b0);
    lookup(32'h0040_0ABC, 8'h05, 1'b0, 2'd0, 32'h1234_5ABC, 1'b1, "R7 even read");
    lookup(32'h0040_1123, 8'h05, 1'b0, 2'd0, 32'h0ABC_D123, 1'b0, "R4 odd read bit12");
    lookup(32'h0040_1123, 8'h05, 1'b1, 2'd3, 32'h0, 1'b0, "R6 store to clean half");
    lookup(32'h0040_0004, 8'h05, 1'b1, 2'd0, 32'h1234_5004, 1'b1, "R6 store to dirty half");
    lookup(32'h0040_0004, 8'h06, 1'b0, 2'd1, 32'h0, 1'b0, "R2 tag mismatch");
    lookup(32'h0040_2004, 8'h05, 1'b0, 2'd1, 32'h0, 1'b0, "R8 next pair misses");
  endtask

  task automatic t_global_invalid;
    write_entry(4'd7, 19'h40000, 19'h0, 8'h00, 1'b1, 20'h00001, 1'b0, 1'b0, 20'h00002, 1'b1, 1'b1);
    lookup(32'h8000_0010, 8'h99, 1'b0, 2'd2, 32'h0, 1'b0, "R5 invalid even half");
    lookup(32'h8000_1010, 8'h99, 1'b1, 2'd0, 32'h0000_2010, 1'b1, "R2 global entry any tag");
  endtask

  task automatic t_large_page;
    write_entry(4'd9, 19'h08000, 19'h3, 8'h01, 1'b0, 20'h40000, 1'b1, 1'b1, 20'h50000, 1'b1, 1'b1);
    lookup(32'h1000_3FFC, 8'h01, 1'b0, 2'd0, 32'h4000_3FFC, 1'b1, "R3 16K even offset");
    lookup(32'h1000_5004, 8'h01, 1'b0, 2'd0, 32'h5000_1004, 1'b1, "R4 16K odd via bit14");
    lookup(32'h1000_8000, 8'h01, 1'b0, 2'd1, 32'h0, 1'b0, "R3 beyond 32K pair");
  endtask

  task automatic t_priority;
    write_entry(4'd12, 19'h10000, 19'h0, 8'h03, 1'b0, 20'h22222, 1'b1, 1'b1, 20'h0, 1'b0, 1'b0);
    write_entry(4'd1,  19'h10000, 19'h0, 8'h03, 1'b0, 20'h11111, 1'b1, 1'b1, 20'h0, 1'b0, 1'b0);
    lookup(32'h2000_0100, 8'h03, 1'b0, 2'd0, 32'h1111_1100, 1'b1, "R9 lowest index wins");
    write_entry(4'd1,  19'h10001, 19'h0, 8'h03, 1'b0, 20'h33333, 1'b1, 1'b0, 20'h0, 1'b0, 1'b0);
    lookup(32'h2000_0100, 8'h03, 1'b0, 2'd0, 32'h2222_2100, 1'b1, "R11 rewrite frees index 12");
    lookup(32'h2000_2100, 8'h03, 1'b0, 2'd0, 32'h3333_3100, 1'b0, "R11 new contents of index 1");
  endtask

  task automatic t_idle;
    lookup(32'h0040_1FFF, 8'h05, 1'b0, 2'd0, 32'h0ABC_DFFF, 1'b0, "R10 response one cycle later");
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_code !== 2'd0 || rsp_paddr !== 32'h0ABC_DFFF) begin
      errors++;
      $display("FAIL R10 idle: got v=%0b code=%0d pa=%h expected v=0 code=0 pa=0abcdfff",
               rsp_valid, rsp_code, rsp_paddr);
    end
  endtask

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_small_page();
    t_global_invalid();
    t_large_page();
    t_priority();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule